// File: doc/BRIEF.md
# Delimited Byte-Stream Frame Extractor

This block sits behind a serial receiver. It takes a raw stream of bytes, one per valid/ready handshake, and recovers the payloads of delimited frames. A start/end code (0x02) brackets each frame. Inside a payload, any byte equal to the start/end code or to the escape code (0x10) is sent with an escape byte in front of it. The extractor removes the escapes and the delimiters, drops everything received between frames, and passes payload bytes downstream. The last payload byte of each frame is marked with `out_last`. The newest payload byte is held back by one position, so the marker can travel with the final byte itself instead of as a separate beat.

The framing machine has four states. `ST_HUNT` is outside a frame with no escape pending; `ST_HUNT_ESC` is outside a frame with an escape pending; `ST_BODY` is inside a frame; `ST_BODY_ESC` is inside a frame with an escape pending. Its transitions are:

- *open*: HUNT to BODY on the start/end code.
- *hunt-escape*: HUNT to HUNT_ESC on the escape code.
- *hunt-skip*: the escape pending in HUNT_ESC is cleared by a start/end code or by a plain byte. Both bytes are dropped, and a repeated escape code keeps the state.
- *body-escape*: BODY to BODY_ESC on the escape code.
- *literal*: BODY_ESC to BODY; the byte is always data.
- *close*: BODY to HUNT on the start/end code when the length is nonzero.
- *resync*: BODY stays in BODY on the start/end code when the length is zero.
- *data*: BODY stays in BODY on any other byte.

An 8-bit saturating counter tracks the frame length.

Top module: `dstf_unstuff`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: Outside a frame, every byte other than an unescaped 0x02 is dropped and produces no output.
- R3: An unescaped 0x02 outside a frame opens a frame. Every later unescaped byte other than 0x02 and 0x10 is output in arrival order.
- R4: An unescaped 0x02 inside a frame that already holds at least one payload byte closes the frame. The 0x02 itself is not output, and the last payload byte is delivered with `out_last` = 1. All other payload bytes have `out_last` = 0.
- R5: An unescaped 0x02 inside a frame that holds no payload yet produces no output, and the block stays inside the frame (resynchronisation). No empty frame is ever reported.
- R6: Inside a frame, an unescaped 0x10 is consumed without output. The byte that follows it is output as data and counted, even if it is 0x02 or 0x10.
- R7: Inside a frame, a byte other than 0x02 or 0x10 that follows an escape is output as ordinary data, and the escape is cleared.
- R8: Outside a frame, a 0x02 that follows an escape is dropped, clears the escape, and does not open a frame. A repeated 0x10 keeps the escape pending.
- R9: While `out_valid` = 1 and `out_ready` = 0, `out_data` and `out_last` hold, and `in_ready` is 0.
- R10: The length count saturates rather than wrapping. A frame of 256 or more payload bytes still closes on the next unescaped 0x02.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte offered |
| in_data | input | 8 | Raw received byte |
| in_ready | output | 1 | Block accepts the offered byte |
| out_valid | output | 1 | Payload byte available |
| out_data | output | 8 | Destuffed payload byte |
| out_last | output | 1 | Marks the final payload byte of a frame |
| out_ready | input | 1 | Downstream accepts the payload byte |

## Verification
The bench drives several kinds of stream:

- plain frames, which confirm ordering and where the end marker falls;
- frames preceded by junk, which show that bytes outside a frame are dropped;
- back-to-back delimiters, which separate resynchronisation from an empty-frame report;
- escaped delimiter and escape bytes inside and outside frames, which show whether the escape is applied in the correct state;
- an escape before an ordinary byte, which checks that the pending escape is cleared;
- a frame of 256 bytes, which exposes a length counter that wraps;
- output stalls during a frame, which separate correct holding of the output from lost or duplicated bytes.

// File: rtl/dstf_pkg.sv
`timescale 1ns/1ps
package dstf_pkg;
    typedef enum logic [1:0] {
        ST_HUNT     = 2'd0,
        ST_HUNT_ESC = 2'd1,
        ST_BODY     = 2'd2,
        ST_BODY_ESC = 2'd3
    } dstf_state_e;

    typedef enum logic [1:0] {
        CLS_PLAIN = 2'd0,
        CLS_SOF   = 2'd1,
        CLS_ESC   = 2'd2
    } dstf_class_e;
endpackage

// File: rtl/dstf_sort.sv
`timescale 1ns/1ps
module dstf_sort
    import dstf_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter logic [DATA_W-1:0] SOF_CODE = 8'h02,
    parameter logic [DATA_W-1:0] ESC_CODE = 8'h10
) (
    input  logic [DATA_W-1:0] byte_in,
    output dstf_class_e       cls
);
    always_comb begin
        if (byte_in == SOF_CODE)      cls = CLS_SOF;
        else if (byte_in == ESC_CODE) cls = CLS_ESC;
        else                          cls = CLS_PLAIN;
    end
endmodule

// File: rtl/dstf_fsm.sv
`timescale 1ns/1ps
module dstf_fsm
    import dstf_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        take,
    input  dstf_class_e cls,
    output logic        push,
    output logic        close,
    output logic        in_frame,
    output logic        esc_pend,
    output logic        len_nz
);
    localparam logic [LEN_W-1:0] LEN_MAX = {LEN_W{1'b1}};

    dstf_state_e      state, state_nxt;
    logic [LEN_W-1:0] len;
    logic             len_clr, len_inc;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_HUNT;
        else        state <= state_nxt;
    end

    // transitions and per-byte actions
    always_comb begin
        state_nxt = state;
        push      = 1'b0;
        close     = 1'b0;
        len_clr   = 1'b0;
        len_inc   = 1'b0;
        if (take) begin
            unique case (state)
                ST_HUNT: begin
                    if (cls == CLS_SOF) begin
                        state_nxt = ST_BODY;          // open
                        len_clr   = 1'b1;
                    end else if (cls == CLS_ESC) begin
                        state_nxt = ST_HUNT_ESC;      // hunt-escape
                    end
                end
                ST_HUNT_ESC: begin
                    if (cls != CLS_ESC) state_nxt = ST_HUNT;  // hunt-skip
                end
                ST_BODY: begin
                    if (cls == CLS_ESC) begin
                        state_nxt = ST_BODY_ESC;      // body-escape
                    end else if (cls == CLS_SOF) begin
                        if (len_nz) begin
                            state_nxt = ST_HUNT;      // close
                            close     = 1'b1;
                            len_clr   = 1'b1;
                        end                           // else resync
                    end else begin
                        push    = 1'b1;               // data
                        len_inc = 1'b1;
                    end
                end
                ST_BODY_ESC: begin
                    state_nxt = ST_BODY;              // literal
                    push      = 1'b1;
                    len_inc   = 1'b1;
                end
                default: state_nxt = ST_HUNT;
            endcase
        end
    end

    // saturating frame length
    always_ff @(posedge clk) begin
        if (!rst_n)                       len <= '0;
        else if (len_clr)                 len <= '0;
        else if (len_inc && len != LEN_MAX) len <= len + 1'b1;
    end

    always_comb begin
        len_nz   = (len != '0);
        in_frame = (state == ST_BODY) || (state == ST_BODY_ESC);
        esc_pend = (state == ST_HUNT_ESC) || (state == ST_BODY_ESC);
    end
endmodule

// File: rtl/dstf_emit.sv
`timescale 1ns/1ps
module dstf_emit #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              push,
    input  logic              close,
    input  logic [DATA_W-1:0] din,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_last,
    output logic              in_ready,
    output logic              hold_valid
);
    logic [DATA_W-1:0] hold;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_data   <= '0;
            out_last   <= 1'b0;
            hold       <= '0;
            hold_valid <= 1'b0;
        end else begin
            if (out_valid && out_ready) out_valid <= 1'b0;
            if (take && push) begin
                if (hold_valid) begin
                    out_valid <= 1'b1;
                    out_data  <= hold;
                    out_last  <= 1'b0;
                end
                hold       <= din;
                hold_valid <= 1'b1;
            end else if (take && close) begin
                out_valid  <= 1'b1;
                out_data   <= hold;
                out_last   <= 1'b1;
                hold_valid <= 1'b0;
            end
        end
    end

    always_comb in_ready = !out_valid || out_ready;
endmodule

// File: rtl/dstf_unstuff.sv
`timescale 1ns/1ps
module dstf_unstuff
    import dstf_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int LEN_W  = 8,
    parameter logic [DATA_W-1:0] SOF_CODE = 8'h02,
    parameter logic [DATA_W-1:0] ESC_CODE = 8'h10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_last,
    input  logic              out_ready
);
    dstf_class_e cls;
    logic take, push, close, in_frame, esc_pend, len_nz, hold_valid;

    always_comb take = in_valid && in_ready;

    dstf_sort #(.DATA_W(DATA_W), .SOF_CODE(SOF_CODE), .ESC_CODE(ESC_CODE)) u_sort (
        .byte_in (in_data),
        .cls     (cls)
    );

    dstf_fsm #(.LEN_W(LEN_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (take),
        .cls      (cls),
        .push     (push),
        .close    (close),
        .in_frame (in_frame),
        .esc_pend (esc_pend),
        .len_nz   (len_nz)
    );

    dstf_emit #(.DATA_W(DATA_W)) u_emit (
        .clk        (clk),
        .rst_n      (rst_n),
        .take       (take),
        .push       (push),
        .close      (close),
        .din        (in_data),
        .out_ready  (out_ready),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .out_last   (out_last),
        .in_ready   (in_ready),
        .hold_valid (hold_valid)
    );
endmodule

// File: rtl/dstf_unstuff_chk.sv
`timescale 1ns/1ps
module dstf_unstuff_chk #(
    parameter int DATA_W = 8,
    parameter logic [DATA_W-1:0] SOF_CODE = 8'h02
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [DATA_W-1:0] in_data,
    input logic              in_ready,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data,
    input logic              out_last,
    input logic              out_ready,
    input logic              in_frame,
    input logic              esc_pend,
    input logic              len_nz,
    input logic              hold_valid
);
    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));
    // R9
    stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready);
    // R4
    close_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && in_data == SOF_CODE && in_frame && !esc_pend && len_nz
        |=> out_valid && out_last);
    // R4
    last_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_last |-> !hold_valid);
    // R5
    resync_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && in_data == SOF_CODE && in_frame && !esc_pend && !len_nz
        |=> in_frame && !out_valid);
    // R2
    hunt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && !in_frame |=> !out_valid);
    // R3
    hold_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_valid == len_nz);
endmodule

bind dstf_unstuff dstf_unstuff_chk #(.DATA_W(DATA_W), .SOF_CODE(SOF_CODE)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .out_last   (out_last),
    .out_ready  (out_ready),
    .in_frame   (in_frame),
    .esc_pend   (esc_pend),
    .len_nz     (len_nz),
    .hold_valid (hold_valid)
);

// File: tb/tb_dstf_unstuff.sv
`timescale 1ns/1ps
module tb_dstf_unstuff;
    localparam logic [7:0] SOF = 8'h02;
    localparam logic [7:0] ESC = 8'h10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_ready;
    logic       out_valid;
    logic [7:0] out_data;
    logic       out_last;
    logic       out_ready = 1'b1;

    always #2.5 clk = ~clk;

    dstf_unstuff dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
        .out_last(out_last), .out_ready(out_ready)
    );

    int    checks = 0;
    int    fails  = 0;
    int    cyc    = 0;
    bit    stall_en = 1'b0;
    string cur_req = "R1";

    // reference model state
    logic [8:0] expq[$];
    bit         m_inf = 0, m_esc = 0, m_hv = 0;
    int         m_len = 0;
    logic [7:0] m_hold = 8'h00;
    bit         prev_stall = 0;
    logic [7:0] prev_d = 8'h00;
    logic       prev_l = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    task automatic m_data(input logic [7:0] b);
        if (m_hv) expq.push_back({1'b0, m_hold});
        m_hold = b;
        m_hv   = 1;
        m_len++;
    endtask

    task automatic m_step(input logic [7:0] b);
        if (!m_inf) begin
            if (m_esc) begin
                if (b != ESC) m_esc = 0;
            end else if (b == SOF) begin
                m_inf = 1; m_len = 0;
            end else if (b == ESC) begin
                m_esc = 1;
            end
        end else begin
            if (m_esc) begin
                m_data(b); m_esc = 0;
            end else if (b == ESC) begin
                m_esc = 1;
            end else if (b == SOF) begin
                if (m_len > 0) begin
                    expq.push_back({1'b1, m_hold});
                    m_hv = 0; m_len = 0; m_inf = 0;
                end
            end else begin
                m_data(b);
            end
        end
    endtask

    // per-clock comparison
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_stall)
                chk(out_valid && out_data == prev_d && out_last == prev_l, "R9",
                    {out_valid, out_last, out_data}, {1'b1, prev_l, prev_d});
            if (out_valid && !out_ready)
                chk(!in_ready, "R9", in_ready, 0);
            prev_stall = out_valid && !out_ready;
            prev_d = out_data;
            prev_l = out_last;
            if (out_valid && out_ready) begin
                if (expq.size() == 0) begin
                    chk(0, cur_req, {out_last, out_data}, 9'h1ff);
                end else begin
                    logic [8:0] e;
                    e = expq.pop_front();
                    chk({out_last, out_data} == e, cur_req, {out_last, out_data}, e);
                end
            end
            if (in_valid && in_ready) m_step(in_data);
        end
    end

    always @(posedge clk) begin
        cyc++;
        #1 out_ready = stall_en ? (cyc % 3 != 0) : 1'b1;
        if (cyc > 100000) begin
            chk(0, "R1 watchdog", cyc, 100000);
            summary();
            $finish;
        end
    end

    task automatic send(input logic [7:0] b);
        @(posedge clk); #1;
        in_valid = 1'b1;
        in_data  = b;
        do @(negedge clk); while (!in_ready);
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    task automatic drain(input string req);
        repeat (10) @(posedge clk);
        @(negedge clk);
        chk(expq.size() == 0, req, expq.size(), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(out_valid == 1'b0, "R1", out_valid, 0);
        chk(in_ready == 1'b1, "R1", in_ready, 1);

        // R3 plain frame
        cur_req = "R3";
        send(SOF); send(8'h11); send(8'h22); send(8'h33); send(SOF);
        drain("R3");

        // R2 junk outside frame, then R4 single-byte frame
        cur_req = "R2";
        send(8'h55); send(8'h66); send(8'h77);
        drain("R2");
        cur_req = "R4";
        send(SOF); send(8'h44); send(SOF);
        drain("R4");

        // R5 back-to-back delimiters resync
        cur_req = "R5";
        send(SOF); send(SOF); send(8'h0a); send(8'h0b); send(SOF);
        drain("R5");

        // R6 escaped delimiter and escape
        cur_req = "R6";
        send(SOF); send(ESC); send(SOF); send(ESC); send(ESC); send(8'h09); send(SOF);
        send(SOF); send(ESC); send(SOF); send(SOF);
        drain("R6");

        // R7 escape before ordinary byte
        cur_req = "R7";
        send(SOF); send(ESC); send(8'h41); send(8'h42); send(SOF);
        drain("R7");

        // R8 escaped delimiter outside a frame
        cur_req = "R8";
        send(ESC); send(SOF); send(8'h61); send(8'h62);
        send(ESC); send(ESC); send(SOF); send(8'h64);
        send(SOF); send(8'h63); send(SOF);
        drain("R8");

        // R9 output stalls inside a frame
        cur_req = "R9";
        stall_en = 1'b1;
        send(SOF);
        for (int i = 0; i < 20; i++) send(8'h80 + 8'(i));
        send(SOF);
        stall_en = 1'b0;
        drain("R9");

        // R10 frame longer than the counter range
        cur_req = "R10";
        send(SOF);
        for (int i = 0; i < 256; i++) begin
            logic [7:0] v;
            v = 8'(i);
            if (v == SOF || v == ESC) v = 8'h20;
            send(v);
        end
        send(SOF);
        drain("R10");

        summary();
        $finish;
    end
endmodule